// File: doc/BRIEF.md
# Mixed-Width Simple Dual-Port RAM

This block is a small embedded memory with a dedicated write port and a dedicated read port over one shared 576-bit array. Each port is given its own shape, a depth-by-width pair, through static parameters. A narrow write port paired with a wide read port collects several narrow words into one wide word, so the block acts as a simple deserializer. The reverse pairing splits wide words into narrow ones and acts as a serializer. Tying the two addresses together gives single-port use.

Each port has its own clock and its own synchronous reset, and its logic runs only in that clock. The read data is registered. A read enable that is low keeps the last output. The array can start from contents supplied as a parameter vector, so no file is needed.

Top module: `mw_sdp_ram`

## Requirements
- R1: The width of each port is 1, 2, 4, 8 or 16, which uses 512 bits of the array, or 9 or 18, which uses all 576 bits. The depth of the port is the used bits divided by its width.
- R2: A data width may be paired only with another data width, and a parity width only with another parity width. The package function `pair_ok(a,b)` returns 0 for any other pairing, and such a pairing is rejected at elaboration.
- R3: The array is addressed in bits. Bit j of word A on a port of width W is flat bit A*W+j. So in a pairing with ratio R, wide word N holds narrow words N*R to N*R+R-1, and the lowest narrow word sits in the least significant bits.
- R4: When `rd_en` is high at a `rd_clk` edge, `rd_data` shows the addressed word after that edge, one read-clock cycle of latency, and not before it.
- R5: While `rd_en` is low, `rd_data` holds its value, even when the read address or the memory contents change.
- R6: A read and a write to the same location on the same edge of a common clock return the data that was there before the write.
- R7: The memory is not changed at a `wr_clk` edge where `wr_en` is low or `wr_rst` is high.
- R8: Before the first write, flat bit b of the array equals bit b of the `INIT` parameter.
- R9: When `rd_rst` is high at a `rd_clk` edge, `rd_data` becomes zero, whatever the value of `rd_en`.
- R10: The write clock and the read clock may be unrelated. Data written in the write domain can be read back correctly through a read clock with a different period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-port clock |
| wr_rst | input | 1 | Synchronous active-high reset of the write port; blocks writes |
| wr_en | input | 1 | Write enable |
| wr_addr | input | WA_W | Word address in write-port words |
| wr_data | input | WR_WIDTH | Word to write |
| rd_clk | input | 1 | Read-port clock |
| rd_rst | input | 1 | Synchronous active-high reset; clears the read register |
| rd_en | input | 1 | Read enable |
| rd_addr | input | RA_W | Word address in read-port words |
| rd_data | output | RD_WIDTH | Registered read word |

## Verification
A 4-bit write port paired with a 16-bit read port is first read back from a non-uniform `INIT` pattern. It is then filled with an address-dependent nibble per narrow word and read back. A swapped or misordered lane shows as a wrong nibble position, and a lost initial vector shows as zeros. Same-edge read-write collisions, writes with the enable low or under write reset, and idle reads with the address and the memory changing under them separate old-data, blocking and hold behaviour from plain writes. A second instance, with 18-bit writes and 9-bit reads on an unrelated read clock, fills all 576 bits. This shows that the parity bits are stored and that the wide-to-narrow split works across domains.

// File: rtl/mwram_pkg.sv
package mwram_pkg;

  // Full size of the shared array, in bits.
  localparam int ARRAY_BITS = 576;
  // Bits in use when only data widths are chosen.
  localparam int DATA_BITS  = 512;

  function automatic bit is_data_w(int w);
    return (w == 1) || (w == 2) || (w == 4) || (w == 8) || (w == 16);
  endfunction

  function automatic bit is_par_w(int w);
    return (w == 9) || (w == 18);
  endfunction

  // Legal combinations of write width and read width.
  function automatic bit pair_ok(int a, int b);
    return (is_data_w(a) && is_data_w(b)) || (is_par_w(a) && is_par_w(b));
  endfunction

  function automatic int used_bits(int w);
    return is_par_w(w) ? ARRAY_BITS : DATA_BITS;
  endfunction

  function automatic int min_w(int a, int b);
    return (a < b) ? a : b;
  endfunction

endpackage

// File: rtl/mwram_unit_addr.sv
// Turns a port word address into the index of its first storage unit.
module mwram_unit_addr #(
  parameter int AW   = 7,
  parameter int SH   = 0,
  localparam int UA_W = AW + SH
) (
  input  logic [AW-1:0]   addr_i,
  output logic [UA_W-1:0] base_o
);

  generate
    if (SH == 0) begin : g_narrow
      // The port is as narrow as a unit: the address is the unit index.
      assign base_o = addr_i;
    end else begin : g_wide
      // The port spans 2**SH units, so the low unit-address bits are zero.
      assign base_o = {addr_i, {SH{1'b0}}};
    end
  endgenerate

endmodule

// File: rtl/mwram_array.sv
// Storage held as units of the narrower port width. The wider port reaches
// RATIO consecutive units at once, with the lowest unit in the low bits.
module mwram_array #(
  parameter int NW       = 4,
  parameter int WR_RATIO = 1,
  parameter int RD_RATIO = 4,
  parameter int UNITS    = 128,
  parameter int UA_W     = 7,
  parameter logic [mwram_pkg::ARRAY_BITS-1:0] INIT = '0,
  localparam int WW = NW * WR_RATIO,
  localparam int RW = NW * RD_RATIO
) (
  input  logic            wr_clk,
  input  logic            wr_rst,
  input  logic            wr_en,
  input  logic [UA_W-1:0] wr_base,
  input  logic [WW-1:0]   wr_data,
  input  logic            rd_clk,
  input  logic            rd_rst,
  input  logic            rd_en,
  input  logic [UA_W-1:0] rd_base,
  output logic [RW-1:0]   rd_data
);

  logic [NW-1:0] mem [UNITS];
  logic [RW-1:0] rd_q;

  // Preload from the parameter vector (R8).
  initial begin
    for (int k = 0; k < UNITS; k++) begin
      mem[k] = INIT[k*NW +: NW];
    end
  end

  // Write port: write domain only.
  always_ff @(posedge wr_clk) begin
    if (wr_en && !wr_rst) begin
      for (int i = 0; i < WR_RATIO; i++) begin
        mem[wr_base + UA_W'(i)] <= wr_data[i*NW +: NW];
      end
    end
  end

  // Read port: a registered output that holds while the enable is low.
  always_ff @(posedge rd_clk) begin
    if (rd_rst) begin
      rd_q <= '0;
    end else if (rd_en) begin
      for (int i = 0; i < RD_RATIO; i++) begin
        rd_q[i*NW +: NW] <= mem[rd_base + UA_W'(i)];
      end
    end
  end

  assign rd_data = rd_q;

  AST_WR_LOW_LANE: assert property (@(posedge wr_clk) disable iff (wr_rst)
    wr_en |=> mem[$past(wr_base)] == $past(wr_data[NW-1:0])) else $error("low lane misplaced"); // R3

  AST_WR_TOP_LANE: assert property (@(posedge wr_clk) disable iff (wr_rst)
    wr_en |=> mem[$past(wr_base) + UA_W'(WR_RATIO-1)] == $past(wr_data[WW-1 -: NW])) else $error("top lane misplaced"); // R3

  AST_WR_BLOCKED: assert property (@(posedge wr_clk) disable iff (wr_rst)
    !wr_en |=> mem[$past(wr_base)] == $past(mem[wr_base])) else $error("unit changed without enable"); // R7

  AST_RD_HOLD: assert property (@(posedge rd_clk) disable iff (rd_rst)
    !rd_en |=> $stable(rd_data)) else $error("read data moved while idle"); // R5

  AST_RD_PRE_EDGE_DATA: assert property (@(posedge rd_clk) disable iff (rd_rst)
    rd_en |=> rd_data[NW-1:0] == $past(mem[rd_base])) else $error("read did not return pre-edge content"); // R4 R6

endmodule

// File: rtl/mw_sdp_ram.sv
module mw_sdp_ram
  import mwram_pkg::*;
#(
  parameter int WR_WIDTH = 4,
  parameter int RD_WIDTH = 16,
  parameter logic [ARRAY_BITS-1:0] INIT = '0,
  localparam int USED  = used_bits(WR_WIDTH),
  localparam int NW    = min_w(WR_WIDTH, RD_WIDTH),
  localparam int UNITS = USED / NW,
  localparam int WA_W  = $clog2(USED / WR_WIDTH),
  localparam int RA_W  = $clog2(USED / RD_WIDTH),
  localparam int UA_W  = $clog2(UNITS)
) (
  input  logic                wr_clk,
  input  logic                wr_rst,
  input  logic                wr_en,
  input  logic [WA_W-1:0]     wr_addr,
  input  logic [WR_WIDTH-1:0] wr_data,
  input  logic                rd_clk,
  input  logic                rd_rst,
  input  logic                rd_en,
  input  logic [RA_W-1:0]     rd_addr,
  output logic [RD_WIDTH-1:0] rd_data
);

  localparam int WR_RATIO = WR_WIDTH / NW;
  localparam int RD_RATIO = RD_WIDTH / NW;
  localparam int WR_SH    = $clog2(WR_RATIO);
  localparam int RD_SH    = $clog2(RD_RATIO);

  initial begin
    AST_SHAPE_PAIR: assert (pair_ok(WR_WIDTH, RD_WIDTH))
      else $error("illegal write/read width pairing"); // R2 R1
  end

  logic [UA_W-1:0] wr_base;
  logic [UA_W-1:0] rd_base;

  mwram_unit_addr #(.AW(WA_W), .SH(WR_SH)) u_wr_addr (
    .addr_i (wr_addr),
    .base_o (wr_base)
  );

  mwram_unit_addr #(.AW(RA_W), .SH(RD_SH)) u_rd_addr (
    .addr_i (rd_addr),
    .base_o (rd_base)
  );

  mwram_array #(
    .NW       (NW),
    .WR_RATIO (WR_RATIO),
    .RD_RATIO (RD_RATIO),
    .UNITS    (UNITS),
    .UA_W     (UA_W),
    .INIT     (INIT)
  ) u_array (
    .wr_clk  (wr_clk),
    .wr_rst  (wr_rst),
    .wr_en   (wr_en),
    .wr_base (wr_base),
    .wr_data (wr_data),
    .rd_clk  (rd_clk),
    .rd_rst  (rd_rst),
    .rd_en   (rd_en),
    .rd_base (rd_base),
    .rd_data (rd_data)
  );

endmodule

// File: tb/sim_mw_sdp_ram.sv
module sim_mw_sdp_ram;
  import mwram_pkg::*;

  localparam logic [575:0] INITP = {18{32'hC39A5E71}};

  logic clk = 1'b0;
  logic rclk1 = 1'b0;
  always #2 clk = ~clk;       // 250 MHz
  always #3.5 rclk1 = ~rclk1; // unrelated read clock for u1

  // u0: 4-bit writes, 16-bit reads, preloaded
  logic        wr_rst0 = 1'b1, wr_en0 = 1'b0, rd_rst0 = 1'b1, rd_en0 = 1'b0;
  logic [6:0]  wr_addr0 = '0;
  logic [3:0]  wr_data0 = '0;
  logic [4:0]  rd_addr0 = '0;
  logic [15:0] rd_data0;

  // u1: 18-bit writes, 9-bit reads
  logic        wr_rst1 = 1'b1, wr_en1 = 1'b0, rd_rst1 = 1'b1, rd_en1 = 1'b0;
  logic [4:0]  wr_addr1 = '0;
  logic [17:0] wr_data1 = '0;
  logic [5:0]  rd_addr1 = '0;
  logic [8:0]  rd_data1;

  mw_sdp_ram #(.WR_WIDTH(4), .RD_WIDTH(16), .INIT(INITP)) u0 (
    .wr_clk(clk), .wr_rst(wr_rst0), .wr_en(wr_en0), .wr_addr(wr_addr0), .wr_data(wr_data0),
    .rd_clk(clk), .rd_rst(rd_rst0), .rd_en(rd_en0), .rd_addr(rd_addr0), .rd_data(rd_data0)
  );

  mw_sdp_ram #(.WR_WIDTH(18), .RD_WIDTH(9)) u1 (
    .wr_clk(clk), .wr_rst(wr_rst1), .wr_en(wr_en1), .wr_addr(wr_addr1), .wr_data(wr_data1),
    .rd_clk(rclk1), .rd_rst(rd_rst1), .rd_en(rd_en1), .rd_addr(rd_addr1), .rd_data(rd_data1)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  bit m0 [576];
  bit m1 [576];
  logic [15:0] exp_q [$];
  string       tag_q [$];
  logic        pend0 = 1'b0;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Flat-bit view of a u0 read word (R3).
  function automatic logic [15:0] exp0(int a);
    logic [15:0] r;
    for (int j = 0; j < 16; j++) r[j] = m0[a*16 + j];
    return r;
  endfunction

  function automatic logic [8:0] exp1(int a);
    logic [8:0] r;
    for (int j = 0; j < 9; j++) r[j] = m1[a*9 + j];
    return r;
  endfunction

  // ---- u0 driver tasks ----
  task automatic rd0(int a, string tag);
    @(negedge clk);
    wr_en0 = 1'b0; rd_en0 = 1'b1; rd_addr0 = 5'(a);
    exp_q.push_back(exp0(a)); tag_q.push_back(tag);
  endtask

  task automatic wr0(int a, logic [3:0] d);
    @(negedge clk);
    rd_en0 = 1'b0; wr_en0 = 1'b1; wr_addr0 = 7'(a); wr_data0 = d;
    if (!wr_rst0) for (int j = 0; j < 4; j++) m0[a*4 + j] = d[j];
  endtask

  task automatic idle0();
    @(negedge clk);
    wr_en0 = 1'b0; rd_en0 = 1'b0;
  endtask

  // ---- u0 monitor ----
  always @(posedge clk) pend0 <= rd_en0 && !rd_rst0;

  always @(negedge clk) begin
    if (pend0) begin
      if (exp_q.size() == 0) begin
        check("R4 unexpected read", 32'(rd_data0), 32'hFFFF_FFFF);
      end else begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, 32'(rd_data0), 32'(e));
      end
    end
  end

  // ---- watchdog ----
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] held;
    for (int b = 0; b < 576; b++) begin
      m0[b] = INITP[b];
      m1[b] = 1'b0;
    end

    // R2: pairing rules
    check("R2 data/parity", 32'(pair_ok(16, 9)), 32'd0);
    check("R2 parity/data", 32'(pair_ok(18, 4)), 32'd0);
    check("R2 data/data", 32'(pair_ok(1, 16)), 32'd1);
    check("R2 parity/parity", 32'(pair_ok(9, 18)), 32'd1);

    // Reset (R9)
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R9 reset u0", 32'(rd_data0), 32'd0);
    wr_rst0 = 1'b0; rd_rst0 = 1'b0;

    // R8: preloaded contents
    for (int a = 0; a < 32; a++) rd0(a, "R8 init");
    idle0(); idle0();

    // R1 R3: narrow fill, wide read-back
    for (int a = 0; a < 128; a++) wr0(a, 4'((a * 7 + 3) & 15));
    for (int a = 0; a < 32; a++) rd0(a, "R3 fill");
    idle0();

    // Second pattern from a small LFSR (R3)
    begin
      logic [7:0] lf = 8'hA1;
      for (int a = 0; a < 128; a++) begin
        lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
        wr0(a, lf[3:0]);
      end
    end
    for (int a = 31; a >= 0; a--) rd0(a, "R3 lfsr");
    idle0();

    // R6: same-edge collision returns old data, then the new data
    @(negedge clk);
    wr_en0 = 1'b1; wr_addr0 = 7'd10; wr_data0 = ~exp0(2)[11:8];
    rd_en0 = 1'b1; rd_addr0 = 5'd2;
    exp_q.push_back(exp0(2)); tag_q.push_back("R6 old data");
    for (int j = 0; j < 4; j++) m0[40 + j] = wr_data0[j];
    rd0(2, "R6 new data");
    idle0();

    // R7: enable low, then write reset high
    @(negedge clk);
    wr_en0 = 1'b0; wr_addr0 = 7'd20; wr_data0 = ~exp0(5)[3:0];
    idle0();
    rd0(5, "R7 enable low");
    idle0();
    wr_rst0 = 1'b1;
    wr0(21, ~exp0(5)[7:4]);
    idle0();
    wr_rst0 = 1'b0;
    rd0(5, "R7 write reset");
    idle0(); idle0();

    // R4: no change before the edge, new word after it
    held = rd_data0;
    @(negedge clk);
    rd_en0 = 1'b1; rd_addr0 = 5'd9;
    check("R4 before edge", 32'(rd_data0), 32'(held));
    exp_q.push_back(exp0(9)); tag_q.push_back("R4 after edge");
    idle0(); idle0();

    // R5: hold while idle, under address and content change
    held = rd_data0;
    @(negedge clk);
    rd_addr0 = 5'd7;
    wr0(36, ~held[3:0]);
    wr0(28, 4'h5);
    idle0();
    rd_addr0 = 5'd0;
    check("R5 hold", 32'(rd_data0), 32'(held));
    idle0();
    check("R5 hold later", 32'(rd_data0), 32'(held));

    // R9: reset wins over enable
    @(negedge clk);
    rd_rst0 = 1'b1; rd_en0 = 1'b1; rd_addr0 = 5'd3;
    @(negedge clk);
    check("R9 reset mid-run", 32'(rd_data0), 32'd0);
    rd_rst0 = 1'b0; rd_en0 = 1'b0;
    idle0();

    // ---- u1: parity widths, unrelated read clock (R1 R10) ----
    @(negedge rclk1);
    @(negedge rclk1);
    check("R9 reset u1", 32'(rd_data1), 32'd0);
    rd_rst1 = 1'b0;
    @(negedge clk);
    wr_rst1 = 1'b0;
    for (int a = 0; a < 32; a++) begin
      logic [17:0] d;
      d = 18'((a * 18'h0B3D) ^ 18'h2C5A7);
      @(negedge clk);
      wr_en1 = 1'b1; wr_addr1 = 5'(a); wr_data1 = d;
      for (int j = 0; j < 18; j++) m1[a*18 + j] = d[j];
    end
    @(negedge clk);
    wr_en1 = 1'b0;
    for (int a = 0; a < 64; a++) begin
      @(negedge rclk1);
      rd_en1 = 1'b1; rd_addr1 = 6'(a);
      @(negedge rclk1);
      rd_en1 = 1'b0;
      check("R10 R1 parity read", 32'(rd_data1), 32'(exp1(a)));
    end

    repeat (4) @(negedge clk);
    check("R4 scoreboard drained", 32'(exp_q.size()), 32'd0);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule